// File: doc/BRIEF.md
# I2C Single-Master Command Engine

This block is the bus-facing half of a single-master I2C controller. A host issues one discrete operation at a time: open a transaction (START), restart it (repeated START), send a byte by writing the data buffer, receive one byte, answer a received byte with an acknowledge bit, or close the transaction (STOP). The engine drives the open-drain SCL and SDA wires through active-high pull-down enables, reads both wires back, and reports through a single event flag plus status bits for start/stop seen, write collision and the acknowledge level returned by the target.

Bus timing comes from a reload counter. Every SCL half-period lasts `baud_reload + 1` clock cycles. While the engine has released SCL and the wire still reads low, the counter freezes, so a target can stretch the clock. The engine cannot queue work. A command or buffer write that arrives while an operation is still running is thrown away and raises a sticky collision flag.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both pull-down enables are 0, `busy`, `irq`, `wcol`, `ack_stat`, `start_seen`, `stop_seen` are 0 and `rd_data` is 0.
- R2: START pulls SDA low with SCL released for one half-period, then also pulls SCL low for one half-period (2 half-periods total). On completion `start_seen`=1 and `stop_seen`=0. START is accepted only when the bus is free (`stop_seen`=1, or both seen bits 0). Otherwise it is dropped and `wcol` is set.
- R3: Repeated START takes 4 half-periods: (SCL low, SDA released), (both released), (SCL released, SDA low), (both low). It sets `start_seen`.
- R4: A buffer write while idle loads `rd_data` and sends the byte MSB first. Each bit is one half-period with SCL low, then one with SCL released. A ninth bit follows with SDA released. `ack_stat` is cleared at acceptance and then takes the level sampled on that ninth bit (1 = NACK). The whole operation takes 18 half-periods.
- R5: A receive command clocks 8 bits with SDA released. It samples SDA at the end of each SCL-high half-period, MSB first, places the byte in `rd_data`, and takes 16 half-periods.
- R6: An acknowledge command sends one bit in 2 half-periods: SDA is pulled low when `ack_level`=0 and released when `ack_level`=1.
- R7: STOP takes 3 half-periods: (both low), (SCL released, SDA low), (both released). It sets `stop_seen` and clears `start_seen`.
- R8: `irq` is set when any operation completes and stays set until `clr_irq` (a completion in the same cycle wins).
- R9: While `busy`=1, any command or buffer write is dropped: `rd_data` and the bus sequence are unaffected, and `wcol` is set until `clr_wcol`.
- R10: While the engine releases SCL and SCL reads low, the half-period counter holds. A stretch of S cycles lengthens the operation by exactly S cycles.
- R11: With `en`=0 the engine returns to idle on the next edge. It releases both wires, clears `start_seen` and `stop_seen`, and ignores commands.
- R12: `busy` rises on the edge that accepts a command and falls on the edge that completes it. An operation of P half-periods therefore keeps `busy` high for P×(`baud_reload`+1) cycles. Simultaneous requests are served in the priority START, repeated START, STOP, acknowledge, receive, write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| baud_reload | input | 7 | Half-period length minus one, in clocks |
| cmd_start | input | 1 | Request START (one-cycle pulse) |
| cmd_rstart | input | 1 | Request repeated START |
| cmd_stop | input | 1 | Request STOP |
| cmd_recv | input | 1 | Request reception of one byte |
| cmd_ack | input | 1 | Request an acknowledge bit |
| ack_level | input | 1 | Level of the acknowledge bit (0 = ACK) |
| wr_valid | input | 1 | Write `wr_data` into the buffer and transmit it |
| wr_data | input | 8 | Byte to transmit |
| clr_irq | input | 1 | Clear the event flag |
| clr_wcol | input | 1 | Clear the collision flag |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Operation in progress |
| rd_data | output | 8 | Data buffer (last byte written or received) |
| irq | output | 1 | Event flag |
| start_seen | output | 1 | START or repeated START completed |
| stop_seen | output | 1 | STOP completed |
| wcol | output | 1 | Sticky collision flag |
| ack_stat | output | 1 | Acknowledge level returned by the target |

## Verification
The bound checker watches several properties on every cycle:
- the collision rule: a busy-time write sets `wcol`, and `rd_data` cannot move except at a completion;
- the stickiness of `irq` and `wcol`;
- the mutual exclusion of the two seen bits;
- the freeze of an operation while a stretched SCL is low;
- the effect of dropping `en`.

The bench scenarios cover the rest:
- the exact wire orderings of START, repeated START and STOP;
- the bit values a target model captures on SCL rising edges, MSB first;
- acknowledge sampling;
- received bytes;
- the exact operation lengths, with and without a stretched clock.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_ST_A,
      PH_ST_B,
      PH_RS_A,
      PH_RS_B,
      PH_RS_C,
      PH_RS_D,
      PH_BIT_LO,
      PH_BIT_HI,
      PH_SP_A,
      PH_SP_B,
      PH_SP_C
   } phase_e;

   typedef enum logic [1:0] {
      OP_TX,
      OP_RX,
      OP_ACK,
      OP_CTL
   } op_e;

endpackage

// File: rtl/i2c_baud_tick.sv
module i2c_baud_tick #(
   parameter int RELOAD_W   = 7,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                scl_released,
   input  logic                scl_in,
   input  logic [RELOAD_W-1:0] reload,
   output logic                phase_done
);

   logic [RELOAD_W-1:0] cnt_q;
   logic                hold;

   generate
      if (STRETCH_EN) begin : g_stretch
         assign hold = scl_released & ~scl_in;
      end else begin : g_free
         logic unused_lines;
         assign unused_lines = scl_released ^ scl_in;
         assign hold = 1'b0;
      end
   endgenerate

   assign phase_done = ~load & ~hold & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load | phase_done) begin
         cnt_q <= reload;
      end else if (!hold && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/i2c_bit_shifter.sv
module i2c_bit_shifter
   import i2c_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  op_e               arm_op,
   input  logic [DATA_W-1:0] arm_data,
   input  logic              arm_ack_lvl,
   input  logic              step,
   input  logic              sda_in,
   output op_e               cur_op,
   output logic              drive_low,
   output logic              last_bit,
   output logic [DATA_W-1:0] rx_next
);

   op_e               op_q;
   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic [CNT_W-1:0]  cnt_q;
   logic              ack_q;

   assign cur_op  = op_q;
   assign rx_next = {rx_sr[DATA_W-2:0], sda_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_CTL;
         tx_sr <= '0;
         rx_sr <= '0;
         cnt_q <= '0;
         ack_q <= 1'b0;
      end else if (arm) begin
         op_q  <= arm_op;
         cnt_q <= '0;
         ack_q <= arm_ack_lvl;
         if (arm_op == OP_TX) tx_sr <= arm_data;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
         tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
         rx_sr <= rx_next;
      end
   end

   always_comb begin
      drive_low = 1'b0;
      last_bit  = 1'b1;
      case (op_q)
         OP_TX: begin
            drive_low = (cnt_q < CNT_W'(DATA_W)) ? ~tx_sr[DATA_W-1] : 1'b0;
            last_bit  = (cnt_q == CNT_W'(DATA_W));
         end
         OP_RX: begin
            drive_low = 1'b0;
            last_bit  = (cnt_q == CNT_W'(DATA_W - 1));
         end
         OP_ACK: begin
            drive_low = ~ack_q;
            last_bit  = (cnt_q == '0);
         end
         default: begin
            drive_low = 1'b0;
            last_bit  = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic set_start,
   input  logic set_stop,
   input  logic set_event,
   input  logic clr_event,
   input  logic set_wcol,
   input  logic clr_wcol,
   input  logic clr_ack,
   input  logic set_ack,
   input  logic ack_val,
   output logic start_seen,
   output logic stop_seen,
   output logic irq,
   output logic wcol,
   output logic ack_stat
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_seen <= 1'b0;
         stop_seen  <= 1'b0;
      end else if (!en) begin
         start_seen <= 1'b0;
         stop_seen  <= 1'b0;
      end else if (set_start) begin
         start_seen <= 1'b1;
         stop_seen  <= 1'b0;
      end else if (set_stop) begin
         start_seen <= 1'b0;
         stop_seen  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         wcol     <= 1'b0;
         ack_stat <= 1'b0;
      end else begin
         if (set_event)      irq <= 1'b1;
         else if (clr_event) irq <= 1'b0;
         if (set_wcol)       wcol <= 1'b1;
         else if (clr_wcol)  wcol <= 1'b0;
         if (clr_ack)        ack_stat <= 1'b0;
         else if (set_ack)   ack_stat <= ack_val;
      end
   end

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
   import i2c_cmd_pkg::*;
#(
   parameter int RELOAD_W   = 7,
   parameter int DATA_W     = 8,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [RELOAD_W-1:0] baud_reload,
   input  logic                cmd_start,
   input  logic                cmd_rstart,
   input  logic                cmd_stop,
   input  logic                cmd_recv,
   input  logic                cmd_ack,
   input  logic                ack_level,
   input  logic                wr_valid,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                clr_irq,
   input  logic                clr_wcol,
   input  logic                scl_in,
   input  logic                sda_in,
   output logic                scl_oe,
   output logic                sda_oe,
   output logic                busy,
   output logic [DATA_W-1:0]   rd_data,
   output logic                irq,
   output logic                start_seen,
   output logic                stop_seen,
   output logic                wcol,
   output logic                ack_stat
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("i2c_cmd_master: DATA_W must be at least 2");
      end
      if (RELOAD_W < 1 || RELOAD_W > 16) begin : g_bad_reload_w
         $error("i2c_cmd_master: RELOAD_W must lie in 1..16");
      end
   endgenerate

   phase_e            phase_q, phase_nx;
   logic              idle_scl_low, idle_sda_low;
   logic [DATA_W-1:0] buf_q;
   logic              in_idle, bus_free, any_req;
   logic              take_start, take_rs, take_sp, take_ack, take_rx, take_tx;
   logic              reject_start, collide;
   logic              arm;
   op_e               arm_op, cur_op;
   logic              phase_done, baud_load, scl_released;
   logic              drive_low, last_bit;
   logic [DATA_W-1:0] rx_next;
   logic              fin_start, fin_stop, fin_bit, fin_tx, fin_rx, op_done;

   // command decode and acceptance
   assign in_idle  = (phase_q == PH_IDLE);
   assign bus_free = stop_seen | (~start_seen & ~stop_seen);
   assign any_req  = cmd_start | cmd_rstart | cmd_stop | cmd_recv | cmd_ack | wr_valid;

   assign take_start   = en & in_idle & cmd_start & bus_free;
   assign reject_start = en & in_idle & cmd_start & ~bus_free;
   assign take_rs      = en & in_idle & ~cmd_start & cmd_rstart;
   assign take_sp      = en & in_idle & ~cmd_start & ~cmd_rstart & cmd_stop;
   assign take_ack     = en & in_idle & ~cmd_start & ~cmd_rstart & ~cmd_stop & cmd_ack;
   assign take_rx      = en & in_idle & ~cmd_start & ~cmd_rstart & ~cmd_stop & ~cmd_ack
                         & cmd_recv;
   assign take_tx      = en & in_idle & ~cmd_start & ~cmd_rstart & ~cmd_stop & ~cmd_ack
                         & ~cmd_recv & wr_valid;
   assign collide      = en & ((~in_idle & any_req) | reject_start);

   assign arm    = take_tx | take_rx | take_ack;
   assign arm_op = take_tx ? OP_TX : (take_rx ? OP_RX : (take_ack ? OP_ACK : OP_CTL));

   // half-period timing
   assign baud_load    = in_idle | ~en;
   assign scl_released = ~in_idle & ~scl_oe;

   i2c_baud_tick #(
      .RELOAD_W   (RELOAD_W),
      .STRETCH_EN (STRETCH_EN)
   ) u_baud (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (baud_load),
      .scl_released (scl_released),
      .scl_in       (scl_in),
      .reload       (baud_reload),
      .phase_done   (phase_done)
   );

   i2c_bit_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (arm),
      .arm_op      (arm_op),
      .arm_data    (wr_data),
      .arm_ack_lvl (ack_level),
      .step        (phase_done & (phase_q == PH_BIT_HI)),
      .sda_in      (sda_in),
      .cur_op      (cur_op),
      .drive_low   (drive_low),
      .last_bit    (last_bit),
      .rx_next     (rx_next)
   );

   // completions
   assign fin_start = phase_done & ((phase_q == PH_ST_B) | (phase_q == PH_RS_D));
   assign fin_stop  = phase_done & (phase_q == PH_SP_C);
   assign fin_bit   = phase_done & (phase_q == PH_BIT_HI) & last_bit;
   assign fin_tx    = fin_bit & (cur_op == OP_TX);
   assign fin_rx    = fin_bit & (cur_op == OP_RX);
   assign op_done   = fin_start | fin_stop | fin_bit;

   always_comb begin
      phase_nx = phase_q;
      case (phase_q)
         PH_ST_A:   phase_nx = PH_ST_B;
         PH_ST_B:   phase_nx = PH_IDLE;
         PH_RS_A:   phase_nx = PH_RS_B;
         PH_RS_B:   phase_nx = PH_RS_C;
         PH_RS_C:   phase_nx = PH_RS_D;
         PH_RS_D:   phase_nx = PH_IDLE;
         PH_SP_A:   phase_nx = PH_SP_B;
         PH_SP_B:   phase_nx = PH_SP_C;
         PH_SP_C:   phase_nx = PH_IDLE;
         PH_BIT_LO: phase_nx = PH_BIT_HI;
         PH_BIT_HI: phase_nx = last_bit ? PH_IDLE : PH_BIT_LO;
         default:   phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q      <= PH_IDLE;
         idle_scl_low <= 1'b0;
         idle_sda_low <= 1'b0;
         buf_q        <= '0;
      end else if (!en) begin
         phase_q      <= PH_IDLE;
         idle_scl_low <= 1'b0;
         idle_sda_low <= 1'b0;
      end else begin
         if (in_idle) begin
            if (take_start)  phase_q <= PH_ST_A;
            else if (take_rs) phase_q <= PH_RS_A;
            else if (take_sp) phase_q <= PH_SP_A;
            else if (arm)     phase_q <= PH_BIT_LO;
         end else if (phase_done) begin
            phase_q <= phase_nx;
         end
         if (take_tx)     buf_q <= wr_data;
         else if (fin_rx) buf_q <= rx_next;
         if (fin_start) begin
            idle_scl_low <= 1'b1;
            idle_sda_low <= 1'b1;
         end else if (fin_stop) begin
            idle_scl_low <= 1'b0;
            idle_sda_low <= 1'b0;
         end else if (fin_bit) begin
            idle_scl_low <= 1'b1;
            idle_sda_low <= 1'b0;
         end
      end
   end

   // wire drive per phase
   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      case (phase_q)
         PH_IDLE:   begin scl_oe = idle_scl_low; sda_oe = idle_sda_low; end
         PH_ST_A:   begin scl_oe = 1'b0;         sda_oe = 1'b1;         end
         PH_ST_B:   begin scl_oe = 1'b1;         sda_oe = 1'b1;         end
         PH_RS_A:   begin scl_oe = 1'b1;         sda_oe = 1'b0;         end
         PH_RS_B:   begin scl_oe = 1'b0;         sda_oe = 1'b0;         end
         PH_RS_C:   begin scl_oe = 1'b0;         sda_oe = 1'b1;         end
         PH_RS_D:   begin scl_oe = 1'b1;         sda_oe = 1'b1;         end
         PH_SP_A:   begin scl_oe = 1'b1;         sda_oe = 1'b1;         end
         PH_SP_B:   begin scl_oe = 1'b0;         sda_oe = 1'b1;         end
         PH_SP_C:   begin scl_oe = 1'b0;         sda_oe = 1'b0;         end
         PH_BIT_LO: begin scl_oe = 1'b1;         sda_oe = drive_low;    end
         PH_BIT_HI: begin scl_oe = 1'b0;         sda_oe = drive_low;    end
         default:   begin scl_oe = 1'b0;         sda_oe = 1'b0;         end
      endcase
   end

   i2c_status_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .set_start  (fin_start),
      .set_stop   (fin_stop),
      .set_event  (op_done),
      .clr_event  (clr_irq),
      .set_wcol   (collide),
      .clr_wcol   (clr_wcol),
      .clr_ack    (take_tx),
      .set_ack    (fin_tx),
      .ack_val    (sda_in),
      .start_seen (start_seen),
      .stop_seen  (stop_seen),
      .irq        (irq),
      .wcol       (wcol),
      .ack_stat   (ack_stat)
   );

   assign busy    = ~in_idle;
   assign rd_data = buf_q;

endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk #(
   parameter int DATA_W     = 8,
   parameter bit STRETCH_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              busy,
   input logic              wr_valid,
   input logic              op_done,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq,
   input logic              clr_irq,
   input logic              wcol,
   input logic              clr_wcol,
   input logic              start_seen,
   input logic              stop_seen,
   input logic              scl_oe,
   input logic              sda_oe,
   input logic              scl_in
);

   p_busy_write_wcol_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && wr_valid) |=> wcol);

   p_wcol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wcol && !clr_wcol) |=> wcol);

   p_buf_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !op_done) |=> $stable(rd_data));

   p_done_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |=> irq);

   p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_irq) |=> irq);

   p_seen_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_seen && stop_seen));

   p_stretch_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n || !en)
      (STRETCH_EN && busy && !scl_oe && !scl_in) |=> busy);

   p_disable_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!busy && !start_seen && !stop_seen && !scl_oe && !sda_oe));

endmodule

bind i2c_cmd_master i2c_cmd_master_chk #(
   .DATA_W     (DATA_W),
   .STRETCH_EN (STRETCH_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .busy       (busy),
   .wr_valid   (wr_valid),
   .op_done    (op_done),
   .rd_data    (rd_data),
   .irq        (irq),
   .clr_irq    (clr_irq),
   .wcol       (wcol),
   .clr_wcol   (clr_wcol),
   .start_seen (start_seen),
   .stop_seen  (stop_seen),
   .scl_oe     (scl_oe),
   .sda_oe     (sda_oe),
   .scl_in     (scl_in)
);

// File: tb/i2c_cmd_master_bench.sv
`timescale 1ns/1ps
module i2c_cmd_master_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [6:0] baud_reload = 7'd3;
   logic       cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_recv = 0, cmd_ack = 0;
   logic       ack_level = 0, wr_valid = 0, clr_irq = 0, clr_wcol = 0;
   logic [7:0] wr_data = 8'h00;
   logic       scl_oe, sda_oe, busy, irq, start_seen, stop_seen, wcol, ack_stat;
   logic [7:0] rd_data;
   logic       scl_line, sda_line;

   always #10 clk = ~clk;

   // target model state
   logic       mon_clear = 1'b0;
   logic       prev_scl = 1'b1;
   int         rise_cnt = 0;
   int         idx = 0;
   logic [7:0] cap = 8'h00;
   logic       cap_ack = 1'b1;
   logic [1:0] sl_mode = 2'd0;
   logic [7:0] rx_pat = 8'h00;
   logic       sl_nack = 1'b0;
   logic       stretch_arm = 1'b0;
   int         stretch_val = 0;
   int         stretch_left = 0;
   logic       slave_sda_pull, stretch_pull;

   assign stretch_pull   = (stretch_left > 0);
   assign slave_sda_pull = ((sl_mode == 2'd1) && (idx < 8) && !rx_pat[3'(7 - idx)]) ||
                           ((sl_mode == 2'd2) && (idx == 8) && !sl_nack);
   assign scl_line = ~(scl_oe | stretch_pull);
   assign sda_line = ~(sda_oe | slave_sda_pull);

   i2c_cmd_master u_i2c_cmd_master (
      .clk (clk), .rst_n (rst_n), .en (en), .baud_reload (baud_reload),
      .cmd_start (cmd_start), .cmd_rstart (cmd_rstart), .cmd_stop (cmd_stop),
      .cmd_recv (cmd_recv), .cmd_ack (cmd_ack), .ack_level (ack_level),
      .wr_valid (wr_valid), .wr_data (wr_data), .clr_irq (clr_irq), .clr_wcol (clr_wcol),
      .scl_in (scl_line), .sda_in (sda_line), .scl_oe (scl_oe), .sda_oe (sda_oe),
      .busy (busy), .rd_data (rd_data), .irq (irq), .start_seen (start_seen),
      .stop_seen (stop_seen), .wcol (wcol), .ack_stat (ack_stat)
   );

   always @(posedge clk) begin
      prev_scl <= scl_line;
      if (mon_clear) begin
         rise_cnt <= 0;
         idx      <= 0;
         cap      <= 8'h00;
         cap_ack  <= 1'b1;
      end else begin
         if (!prev_scl && scl_line) begin
            rise_cnt <= rise_cnt + 1;
            if (rise_cnt < 8)       cap     <= {cap[6:0], sda_line};
            else if (rise_cnt == 8) cap_ack <= sda_line;
         end
         if (prev_scl && !scl_line) idx <= rise_cnt;
      end
   end

   always @(posedge clk) begin
      if (stretch_arm)                         stretch_left <= stretch_val;
      else if (!scl_oe && stretch_left > 0)    stretch_left <= stretch_left - 1;
   end

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;
   logic first_scl, first_sda, first_busy;

   task automatic check_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input int which, input logic [7:0] d);
      @(negedge clk);
      case (which)
         0: cmd_start = 1'b1;
         1: cmd_rstart = 1'b1;
         2: cmd_stop = 1'b1;
         3: cmd_ack = 1'b1;
         4: cmd_recv = 1'b1;
         default: begin wr_valid = 1'b1; wr_data = d; end
      endcase
      @(posedge clk); #1;
      cmd_start = 0; cmd_rstart = 0; cmd_stop = 0; cmd_recv = 0; cmd_ack = 0; wr_valid = 0;
      first_scl = scl_oe; first_sda = sda_oe; first_busy = busy;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 20000) begin
         @(posedge clk); #1;
         n++;
      end
   endtask

   task automatic run(input int which, input logic [7:0] d, output int n);
      issue(which, d);
      wait_idle(n);
   endtask

   task automatic pulse_clear_irq();
      @(negedge clk); clr_irq = 1'b1;
      @(posedge clk); #1; clr_irq = 1'b0;
   endtask

   task automatic pulse_clear_wcol();
      @(negedge clk); clr_wcol = 1'b1;
      @(posedge clk); #1; clr_wcol = 1'b0;
   endtask

   task automatic pulse_mon_clear();
      @(negedge clk); mon_clear = 1'b1;
      @(posedge clk); #1; mon_clear = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // {is_rx, nack, data[7:0], reload[6:0]}
   localparam int NVEC = 7;
   localparam logic [16:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 8'hA5, 7'd3},
      {1'b0, 1'b1, 8'h3C, 7'd0},
      {1'b0, 1'b0, 8'h80, 7'd5},
      {1'b1, 1'b0, 8'h5A, 7'd2},
      {1'b1, 1'b0, 8'hFF, 7'd1},
      {1'b1, 1'b0, 8'h01, 7'd4},
      {1'b0, 1'b1, 8'h00, 7'd2}
   };

   initial begin
      #4000000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         finish_run();
      end
   end

   initial begin
      int n;
      repeat (3) @(posedge clk);
      #1;
      check_eq("R1 scl_oe", scl_oe, 0);
      check_eq("R1 sda_oe", sda_oe, 0);
      check_eq("R1 busy", busy, 0);
      check_eq("R1 seen bits", {start_seen, stop_seen}, 0);
      check_eq("R1 irq/wcol/ack", {irq, wcol, ack_stat}, 0);
      check_eq("R1 rd_data", rd_data, 0);
      @(negedge clk); rst_n = 1'b1; en = 1'b1;

      // R2: START from a free bus
      baud_reload = 7'd3;
      run(0, 8'h00, n);
      check_eq("R12 busy on accept", first_busy, 1);
      check_eq("R2 first phase scl", first_scl, 0);
      check_eq("R2 first phase sda", first_sda, 1);
      check_eq("R2 start length", n, 8);
      check_eq("R2 start_seen/stop_seen", {start_seen, stop_seen}, 2'b10);
      check_eq("R2 lines held low", {scl_oe, sda_oe}, 2'b11);
      check_eq("R8 irq after start", irq, 1);
      pulse_clear_irq();
      check_eq("R8 irq cleared", irq, 0);

      // R4/R5: vector table
      for (int i = 0; i < NVEC; i++) begin
         logic [16:0] v;
         v = VEC[i];
         baud_reload = v[6:0];
         pulse_mon_clear();
         if (!v[16]) begin
            sl_mode = 2'd2; sl_nack = v[15];
            run(5, v[14:7], n);
            check_eq("R4 byte seen by target", cap, v[14:7]);
            check_eq("R4 ack_stat", ack_stat, v[15]);
            check_eq("R4 transmit length", n, 18 * (v[6:0] + 1));
            check_eq("R4 rd_data holds written byte", rd_data, v[14:7]);
         end else begin
            sl_mode = 2'd1; rx_pat = v[14:7];
            run(4, 8'h00, n);
            check_eq("R5 received byte", rd_data, v[14:7]);
            check_eq("R5 receive length", n, 16 * (v[6:0] + 1));
         end
         check_eq("R8 irq after byte", irq, 1);
         sl_mode = 2'd0;
         pulse_clear_irq();
      end

      // R6: acknowledge bit
      baud_reload = 7'd2;
      ack_level = 1'b0;
      pulse_mon_clear();
      run(3, 8'h00, n);
      check_eq("R6 ack driven low", cap[0], 0);
      check_eq("R6 ack length", n, 6);
      check_eq("R8 irq after ack", irq, 1);
      ack_level = 1'b1;
      pulse_mon_clear();
      run(3, 8'h00, n);
      check_eq("R6 nack released", cap[0], 1);
      pulse_clear_irq();

      // R9: collision while transmitting
      baud_reload = 7'd3;
      sl_mode = 2'd2; sl_nack = 1'b0;
      pulse_mon_clear();
      issue(5, 8'h12);
      repeat (5) @(posedge clk);
      issue(5, 8'hC3);
      issue(2, 8'h00);
      wait_idle(n);
      check_eq("R9 buffer keeps first byte", rd_data, 8'h12);
      check_eq("R9 bus carried first byte", cap, 8'h12);
      check_eq("R9 wcol set", wcol, 1);
      check_eq("R9 dropped stop", stop_seen, 0);
      repeat (10) @(posedge clk);
      #1;
      check_eq("R9 wcol sticky", wcol, 1);
      pulse_clear_wcol();
      check_eq("R9 wcol cleared", wcol, 0);
      sl_mode = 2'd0;
      pulse_clear_irq();

      // R2: START refused while bus owned
      issue(0, 8'h00);
      check_eq("R2 start refused busy", busy, 0);
      @(posedge clk); #1;
      check_eq("R2 start refused wcol", wcol, 1);
      pulse_clear_wcol();

      // R10: clock stretching
      baud_reload = 7'd2;
      sl_mode = 2'd2; sl_nack = 1'b0;
      pulse_mon_clear();
      stretch_val = 7;
      @(negedge clk); stretch_arm = 1'b1;
      @(posedge clk); #1; stretch_arm = 1'b0;
      run(5, 8'h6B, n);
      check_eq("R10 stretched length", n, 18 * 3 + 7);
      check_eq("R10 byte intact", cap, 8'h6B);
      sl_mode = 2'd0;
      pulse_clear_irq();

      // R3: repeated START
      baud_reload = 7'd1;
      run(1, 8'h00, n);
      check_eq("R3 rstart length", n, 8);
      check_eq("R3 first phase", {first_scl, first_sda}, 2'b10);
      check_eq("R3 start_seen", start_seen, 1);
      check_eq("R8 irq after rstart", irq, 1);
      pulse_clear_irq();

      // R7: STOP
      baud_reload = 7'd4;
      run(2, 8'h00, n);
      check_eq("R7 stop length", n, 15);
      check_eq("R7 first phase", {first_scl, first_sda}, 2'b11);
      check_eq("R7 seen bits", {start_seen, stop_seen}, 2'b01);
      check_eq("R7 lines released", {scl_oe, sda_oe}, 2'b00);
      check_eq("R8 irq after stop", irq, 1);
      pulse_clear_irq();

      // R2: START accepted after STOP
      run(0, 8'h00, n);
      check_eq("R2 start after stop", n, 10);

      // R11: disable mid-operation
      baud_reload = 7'd3;
      issue(4, 8'h00);
      repeat (3) @(posedge clk);
      @(negedge clk); en = 1'b0;
      @(posedge clk); #1;
      check_eq("R11 busy dropped", busy, 0);
      check_eq("R11 seen bits cleared", {start_seen, stop_seen}, 0);
      check_eq("R11 lines released", {scl_oe, sda_oe}, 0);
      pulse_clear_wcol();
      issue(0, 8'h00);
      check_eq("R11 command ignored", busy, 0);
      check_eq("R11 no collision", wcol, 0);

      finished = 1'b1;
      finish_run();
   end

endmodule